// File: doc/BRIEF.md
# I2C Master Byte Sequencer

This block sits between a small register bank and a bit-level I2C engine. Software writes a control word, a byte count and a target address. In transmit mode it also fills a 16-entry byte FIFO. Writing the address starts the transfer. The sequencer then issues byte-level commands to the bit engine, one at a time, over a request/done handshake: start, repeated start, write byte, read byte with acknowledge or not-acknowledge, and stop. Serialising bits, generating SCL and dividing the clock are the engine's job.

In receive mode the byte count counts down once per received byte. The byte that brings it to zero is always answered with a not-acknowledge, even when the hold bit is set. While the FIFO is full, no further read is requested, so the engine keeps the clock stretched and no byte is lost. The hold bit keeps the bus claimed once the queued work is done. This allows more data, a new count, or a new address that produces a repeated start.

Events are collected in a sticky, write-one-to-clear event register. Any set bit raises the interrupt line.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After reset no command is requested, the interrupt line is low, and the status register (select 1) reads zero.
- R2: A write to the address register (select 2) starts a transfer with a START command only while control bit 1 (master) is set. Only bits [9:0] are kept and read back.
- R3: With control bit 2 set, a single address byte {addr[6:0], rx} is sent. With it clear, the bytes are {11110, addr[9:8], 0} and addr[7:0]. A receive in this case then adds a repeated start and {11110, addr[9:8], 1}.
- R4: In transmit (control bit 0 clear), the FIFO bytes are written in the order queued, and the size register (select 5) reads the number still queued. When the FIFO empties with hold clear, a STOP follows, and its completion sets event bit 0 (COMP).
- R5: With hold (control bit 4) set, an empty transmit FIFO or a zero receive count sets COMP and keeps the bus busy without a STOP. Clearing hold then issues the STOP and frees the bus.
- R6: In receive, one READ is issued per count, each acknowledged when control bit 3 is set. The read that brings the count to zero is not acknowledged, even under hold. The size register reads the remaining count.
- R7: In receive, no READ is requested while the FIFO holds 16 bytes. Reads resume as software drains it, so event bit 5 (RX_OVF) is never set.
- R8: Event bit 1 (DATA) is set when the receive FIFO fills to 14 entries.
- R9: A not-acknowledge on any written byte sets event bit 2 (NACK), skips the remaining bytes, issues a STOP and does not set COMP.
- R10: A data write (select 3) in transmit mode with the FIFO full sets event bit 6 (TX_OVF) and drops the byte. A data read in receive mode with the FIFO empty sets event bit 7 (RX_UNF) and returns zero.
- R11: Writing control bit 6 empties the FIFO within one clock, and the bit reads back as zero.
- R12: Status bit 5 is set while the receive FIFO holds data, and status bit 8 while the bus is claimed. The interrupt line is the OR of the event bits. Writing ones to the event register (select 4) clears those bits.
- R13: A master-mode address write while the bus is held issues a repeated start, followed by the address bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO on a data read) |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 10 | Register write data |
| reg_rdata | output | 10 | Register read data, combinational from reg_sel |
| irq | output | 1 | OR of the event bits |
| cmd_valid | output | 1 | Command request to the bit engine |
| cmd_op | output | 3 | 0 start, 1 repeated start, 2 write, 3 read, 4 stop |
| cmd_byte | output | 8 | Byte to write |
| cmd_ack | output | 1 | For reads: 1 acknowledge, 0 not-acknowledge |
| cmd_done | input | 1 | One-cycle completion of the requested command |
| cmd_nack | input | 1 | With cmd_done on a write: target did not acknowledge |
| cmd_rdata | input | 8 | With cmd_done on a read: received byte |

## Verification
On every cycle the assertions check four things: the FIFO never exceeds its depth, the engine never delivers a read into a full FIFO, an acknowledged read always leaves a non-zero count, and a write not-acknowledge is followed at once by a STOP request. They also check that the bus is released only right after a completed STOP and that clearing the FIFO empties it. Only the bench scenarios can show the rest. That covers the exact command and address byte order for both address widths, the hold and repeated-start sequences, and the stall-and-resume of a 20-byte receive. It also covers the event bits seen through the register interface and the data returned byte by byte.

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq #(
  parameter int DEPTH    = 16,
  parameter int DATA_LVL = DEPTH - 2,
  parameter int SIZE_W   = 8,
  parameter int AW       = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_sel,
  input  logic [AW-1:0]     reg_wdata,
  output logic [AW-1:0]     reg_rdata,
  output logic              irq,
  output logic              cmd_valid,
  output logic [2:0]        cmd_op,
  output logic [7:0]        cmd_byte,
  output logic              cmd_ack,
  input  logic              cmd_done,
  input  logic              cmd_nack,
  input  logic [7:0]        cmd_rdata
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  localparam logic [2:0] R_CTRL = 3'd0, R_STAT = 3'd1, R_ADDR = 3'd2,
                         R_DATA = 3'd3, R_ISR = 3'd4, R_SIZE = 3'd5;
  localparam logic [2:0] OP_START = 3'd0, OP_RSTART = 3'd1, OP_WRITE = 3'd2,
                         OP_READ = 3'd3, OP_STOP = 3'd4;
  localparam int E_COMP = 0, E_DATA = 1, E_NACK = 2, E_RXOVF = 5,
                 E_TXOVF = 6, E_RXUNF = 7;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_AHI, S_ALO, S_RS2, S_AHI2, S_TX, S_RX, S_HOLD, S_STOP
  } st_t;

  st_t              st;
  logic             rs_q, abort_q;
  logic             c_rx, c_ms, c_seven, c_ack, c_hold;
  logic [AW-1:0]    addr_q;
  logic [SIZE_W-1:0] size_q;
  logic [7:0]       isr_q, isr_set;
  logic [7:0]       mem [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;

  wire wr_ctrl = reg_wr && reg_sel == R_CTRL;
  wire wr_addr = reg_wr && reg_sel == R_ADDR;
  wire wr_data = reg_wr && reg_sel == R_DATA;
  wire wr_isr  = reg_wr && reg_sel == R_ISR;
  wire wr_size = reg_wr && reg_sel == R_SIZE;
  wire rd_data = reg_rd && reg_sel == R_DATA;

  wire empty    = cnt == '0;
  wire full     = cnt == CW'(DEPTH);
  wire fifo_clr = wr_ctrl && reg_wdata[6];
  wire step     = cmd_valid && cmd_done;
  wire go       = wr_addr && c_ms;
  wire busy     = st != S_IDLE;
  wire size_z   = size_q == '0;

  wire eng_rx  = st == S_RX && step;
  wire push    = (eng_rx && !full) || (wr_data && !c_rx && !full);
  wire pop     = (rd_data && c_rx && !empty) || (st == S_TX && step);
  wire [7:0] push_d = eng_rx ? cmd_rdata : reg_wdata[7:0];

  always_comb begin
    cmd_valid = 1'b0;
    cmd_op    = OP_WRITE;
    cmd_byte  = 8'h00;
    cmd_ack   = 1'b0;
    unique case (st)
      S_START: begin cmd_valid = 1'b1; cmd_op = rs_q ? OP_RSTART : OP_START; end
      S_AHI: begin
        cmd_valid = 1'b1;
        cmd_byte  = c_seven ? {addr_q[6:0], c_rx} : {5'b11110, addr_q[9:8], 1'b0};
      end
      S_ALO:  begin cmd_valid = 1'b1; cmd_byte = addr_q[7:0]; end
      S_RS2:  begin cmd_valid = 1'b1; cmd_op = OP_RSTART; end
      S_AHI2: begin cmd_valid = 1'b1; cmd_byte = {5'b11110, addr_q[9:8], 1'b1}; end
      S_TX:   begin cmd_valid = !empty; cmd_byte = mem[rp]; end
      S_RX: begin
        cmd_valid = !size_z && !full;
        cmd_op    = OP_READ;
        cmd_ack   = c_ack && size_q != SIZE_W'(1);
      end
      S_STOP: begin cmd_valid = 1'b1; cmd_op = OP_STOP; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; rs_q <= 1'b0; abort_q <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (go) begin st <= S_START; rs_q <= 1'b0; abort_q <= 1'b0; end
        S_START: if (step) st <= S_AHI;
        S_AHI: if (step) begin
          if (cmd_nack) begin st <= S_STOP; abort_q <= 1'b1; end
          else if (c_seven) st <= c_rx ? S_RX : S_TX;
          else st <= S_ALO;
        end
        S_ALO: if (step) begin
          if (cmd_nack) begin st <= S_STOP; abort_q <= 1'b1; end
          else st <= c_rx ? S_RS2 : S_TX;
        end
        S_RS2: if (step) st <= S_AHI2;
        S_AHI2: if (step) begin
          if (cmd_nack) begin st <= S_STOP; abort_q <= 1'b1; end
          else st <= S_RX;
        end
        S_TX: begin
          if (empty) st <= c_hold ? S_HOLD : S_STOP;
          else if (step && cmd_nack) begin st <= S_STOP; abort_q <= 1'b1; end
        end
        S_RX: if (size_z) st <= c_hold ? S_HOLD : S_STOP;
        S_HOLD: begin
          if (go) begin st <= S_START; rs_q <= 1'b1; abort_q <= 1'b0; end
          else if (!c_rx && !empty) st <= S_TX;
          else if (c_rx && !size_z) st <= S_RX;
          else if (!c_hold) st <= S_STOP;
        end
        S_STOP: if (step) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {c_hold, c_ack, c_seven, c_ms, c_rx} <= '0;
      addr_q <= '0;
      size_q <= '0;
    end else begin
      if (wr_ctrl) {c_hold, c_ack, c_seven, c_ms, c_rx} <= reg_wdata[4:0];
      if (wr_addr) addr_q <= reg_wdata;
      if (wr_size) size_q <= reg_wdata[SIZE_W-1:0];
      else if (eng_rx) size_q <= size_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (fifo_clr) begin
      wp <= '0; rp <= '0; cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push) begin mem[wp] <= push_d; wp <= wp + 1'b1; end
      if (pop) rp <= rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_comb begin
    isr_set = '0;
    isr_set[E_COMP]  = (st == S_STOP && step && !abort_q) ||
                       (st == S_TX && empty && c_hold) ||
                       (st == S_RX && size_z && c_hold);
    isr_set[E_DATA]  = c_rx && push && !pop && cnt == CW'(DATA_LVL - 1);
    isr_set[E_NACK]  = step && cmd_nack && cmd_op == OP_WRITE;
    isr_set[E_RXOVF] = eng_rx && full;
    isr_set[E_TXOVF] = wr_data && !c_rx && full;
    isr_set[E_RXUNF] = rd_data && c_rx && empty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_q <= '0;
    else isr_q <= (isr_q & ~(wr_isr ? reg_wdata[7:0] : 8'h00)) | isr_set;
  end

  assign irq = |isr_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      R_CTRL: reg_rdata[4:0] = {c_hold, c_ack, c_seven, c_ms, c_rx};
      R_STAT: begin reg_rdata[8] = busy; reg_rdata[5] = c_rx && !empty; end
      R_ADDR: reg_rdata = addr_q;
      R_DATA: reg_rdata[7:0] = (c_rx && !empty) ? mem[rp] : 8'h00;
      R_ISR:  reg_rdata[7:0] = isr_q;
      R_SIZE: reg_rdata[SIZE_W-1:0] = c_rx ? size_q : SIZE_W'(cnt);
      default: ;
    endcase
  end

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH)); // R7
  AST_NO_READ_INTO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && cmd_op == OP_READ) |-> !full); // R7
  AST_ACKED_READ_NOT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cmd_op == OP_READ && cmd_ack && !wr_size) |=> !size_z); // R6
  AST_NACK_THEN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cmd_nack && cmd_op == OP_WRITE) |=> (cmd_valid && cmd_op == OP_STOP)); // R9
  AST_RELEASE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(step && cmd_op == OP_STOP)); // R5
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> empty); // R11
endmodule

// File: tb/tb_i2c_xfer_seq.sv
module tb_i2c_xfer_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_sel = 0;
  logic [9:0] reg_wdata = 0, reg_rdata;
  logic irq, cmd_valid, cmd_ack;
  logic [2:0] cmd_op;
  logic [7:0] cmd_byte;
  logic cmd_done = 0, cmd_nack = 0;
  logic [7:0] cmd_rdata = 0;

  i2c_xfer_seq dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_ack(cmd_ack), .cmd_done(cmd_done),
    .cmd_nack(cmd_nack), .cmd_rdata(cmd_rdata));

  int checks = 0, fails = 0;
  bit finished = 0;

  int nlog = 0, ne = 0, nack_at = -1, rx_n = 0, wcnt = 0;
  logic [2:0] lop [512];
  logic [7:0] lby [512];
  logic       lack [512];
  logic [2:0] eop [512];
  logic [7:0] eby [512];
  logic       eack [512];
  logic [7:0] rx_hist [512];

  // bit-engine model: random latency, logs each command
  always @(negedge clk) begin
    if (cmd_done) begin
      cmd_done = 0; cmd_nack = 0;
    end else if (rst_n && cmd_valid) begin
      if (wcnt > 0) wcnt--;
      else begin
        lop[nlog] = cmd_op; lby[nlog] = cmd_byte; lack[nlog] = cmd_ack;
        cmd_nack = (cmd_op == 3'd2 && nlog == nack_at);
        if (cmd_op == 3'd3) begin
          cmd_rdata = 8'($urandom); rx_hist[rx_n] = cmd_rdata; rx_n++;
        end
        nlog++; cmd_done = 1; wcnt = int'($urandom % 3);
      end
    end
  end

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [9:0] d);
    @(negedge clk); reg_sel = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [9:0] d);
    @(negedge clk); reg_sel = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic ex(input logic [2:0] op, input logic [7:0] b, input logic a);
    eop[ne] = op; eby[ne] = b; eack[ne] = a; ne++;
  endtask

  task automatic wait_log(input int n);
    for (int i = 0; i < 3000; i++) begin
      if (nlog >= n) break;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic cmp(input string rq);
    chk({rq, " command count"}, nlog, ne);
    for (int i = 0; i < ne && i < nlog; i++) begin
      chk({rq, " op"}, lop[i], eop[i]);
      if (eop[i] == 3'd2) chk({rq, " byte"}, lby[i], eby[i]);
      if (eop[i] == 3'd3) chk({rq, " ack"}, lack[i], eack[i]);
    end
  endtask

  task automatic fresh();
    nlog = 0; ne = 0; rx_n = 0;
    wr(3'd4, 10'h0FF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [9:0] v;
    logic [7:0] d [16];
    void'($urandom(32'h1C2B));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cmd_valid", cmd_valid, 0);
    chk("R1 irq", irq, 0);
    rd(3'd1, v); chk("R1 status", v, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 no start outside master mode
    wr(3'd0, 10'h004); wr(3'd2, 10'h012);
    repeat (20) @(negedge clk);
    chk("R2 no start when not master", nlog, 0);
    rd(3'd1, v); chk("R2 idle busy", v[8], 0);

    // R2 R3 R4 seven-bit transmit
    fresh();
    wr(3'd0, 10'h006);
    for (int i = 0; i < 3; i++) begin d[i] = 8'($urandom); wr(3'd3, {2'b0, d[i]}); end
    rd(3'd5, v); chk("R4 queued count", v, 3);
    wr(3'd2, 10'h3A5);
    rd(3'd2, v); chk("R2 address bits kept", v, 10'h3A5);
    ex(0, 0, 0); ex(2, 8'h4A, 0);
    for (int i = 0; i < 3; i++) ex(2, d[i], 0);
    ex(4, 0, 0);
    wait_log(ne);
    cmp("R3 R4 seven-bit transmit");
    rd(3'd4, v); chk("R4 COMP after stop", v, 10'h001);
    chk("R12 irq set", irq, 1);
    wr(3'd4, 10'h001);
    @(negedge clk); chk("R12 irq cleared", irq, 0);

    // R3 R6 ten-bit receive
    fresh();
    wr(3'd0, 10'h00B); wr(3'd5, 10'd2); wr(3'd2, 10'h2C7);
    ex(0, 0, 0); ex(2, 8'hF4, 0); ex(2, 8'hC7, 0); ex(1, 0, 0); ex(2, 8'hF5, 0);
    ex(3, 0, 1); ex(3, 0, 0); ex(4, 0, 0);
    wait_log(ne);
    cmp("R3 R6 ten-bit receive");
    rd(3'd1, v); chk("R12 rx data valid", v[5], 1);
    rd(3'd5, v); chk("R6 count drained", v, 0);
    for (int i = 0; i < 2; i++) begin rd(3'd3, v); chk("R6 rx data", v, rx_hist[i]); end
    rd(3'd1, v); chk("R12 rx data valid clear", v[5], 0);
    rd(3'd4, v); chk("R4 COMP receive", v, 10'h001);

    // R5 R6 R7 R8 long receive under hold
    fresh();
    wr(3'd0, 10'h01F); wr(3'd5, 10'd20); wr(3'd2, 10'h011);
    repeat (300) @(negedge clk);
    chk("R7 stalled at full FIFO", nlog, 18);
    chk("R3 seven-bit read address", lby[1], 8'h23);
    rd(3'd4, v);
    chk("R8 DATA event", v[1], 1);
    chk("R7 no RX_OVF", v[5], 0);
    rd(3'd5, v); chk("R6 remaining count", v, 4);
    begin
      int got = 0;
      for (int k = 0; k < 4000 && got < 20; k++) begin
        rd(3'd1, v);
        if (v[5]) begin
          rd(3'd3, v);
          if (v != rx_hist[got]) chk("R7 rx data order", v, rx_hist[got]);
          got++;
        end
      end
      chk("R7 all bytes delivered", got, 20);
    end
    wait_log(22);
    chk("R6 acked before last", lack[20], 1);
    chk("R6 last read NACK under hold", lack[21], 0);
    chk("R5 no stop while held", nlog, 22);
    rd(3'd1, v); chk("R5 bus held", v[8], 1);
    rd(3'd4, v); chk("R5 COMP on hold", v[0], 1);
    wr(3'd0, 10'h00F);
    wait_log(23);
    chk("R5 stop after hold clear", lop[22], 4);
    rd(3'd1, v); chk("R5 bus released", v[8], 0);

    // R13 repeated start while held
    fresh();
    wr(3'd0, 10'h016); wr(3'd3, 10'h09C); wr(3'd2, 10'h050);
    wait_log(3);
    rd(3'd1, v); chk("R5 held after transmit", v[8], 1);
    rd(3'd4, v); chk("R5 COMP held transmit", v[0], 1);
    wr(3'd2, 10'h051);
    wait_log(5);
    wr(3'd0, 10'h006);
    wait_log(6);
    ex(0, 0, 0); ex(2, 8'hA0, 0); ex(2, 8'h9C, 0); ex(1, 0, 0); ex(2, 8'hA2, 0); ex(4, 0, 0);
    cmp("R13 repeated start");

    // R9 data NACK, R11 clear FIFO
    fresh();
    wr(3'd0, 10'h006); wr(3'd3, 10'h011); wr(3'd3, 10'h022);
    nack_at = 2;
    wr(3'd2, 10'h033);
    ex(0, 0, 0); ex(2, 8'h66, 0); ex(2, 8'h11, 0); ex(4, 0, 0);
    wait_log(ne);
    cmp("R9 NACK ends transfer");
    rd(3'd4, v); chk("R9 NACK event without COMP", v, 10'h004);
    nack_at = -1;
    rd(3'd5, v); chk("R4 one byte left", v, 1);
    wr(3'd0, 10'h046);
    rd(3'd5, v); chk("R11 FIFO cleared", v, 0);
    rd(3'd0, v); chk("R11 clear bit reads zero", v[6], 0);

    // R10 overflow and underflow
    fresh();
    wr(3'd0, 10'h004);
    for (int i = 0; i < 17; i++) wr(3'd3, 10'($urandom % 256));
    rd(3'd4, v); chk("R10 TX_OVF", v[6], 1);
    rd(3'd5, v); chk("R10 overflow byte dropped", v, 16);
    wr(3'd0, 10'h044); wr(3'd0, 10'h005); wr(3'd4, 10'h0FF);
    rd(3'd3, v); chk("R10 empty read returns zero", v, 0);
    rd(3'd4, v); chk("R10 RX_UNF", v, 10'h080);
    wr(3'd4, 10'h0FF);

    // R3 R4 random transmits, both address widths
    for (int it = 0; it < 12; it++) begin
      int len = 1 + int'($urandom % 16);
      logic [9:0] a = 10'($urandom);
      bit ten = it[0];
      fresh();
      wr(3'd0, ten ? 10'h002 : 10'h006);
      ex(0, 0, 0);
      if (ten) begin ex(2, {5'b11110, a[9:8], 1'b0}, 0); ex(2, a[7:0], 0); end
      else ex(2, {a[6:0], 1'b0}, 0);
      for (int i = 0; i < len; i++) begin d[i] = 8'($urandom); wr(3'd3, {2'b0, d[i]}); ex(2, d[i], 0); end
      ex(4, 0, 0);
      rd(3'd5, v); chk("R4 random queued count", v, len);
      wr(3'd2, a);
      wait_log(ne);
      cmp("R3 R4 random transmit");
      rd(3'd4, v); chk("R4 random COMP", v, 10'h001);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule